// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Message Unit

This block joins two processors, called side A and side B, that share one clock. Each direction has four lanes, and each lane carries one 32-bit word. A word that one side writes into its transmit register for lane n lands in the other side's receive register for lane n. Two things happen at the same clock edge: the receiving side's full flag for that lane goes high, and the sending side's empty flag goes low. When the receiver reads the word back, its full flag drops and the sender's empty flag rises at the same edge. Software on either side can poll these flags or let them raise that side's interrupt line.

Each side has its own small synchronous register port:

- **Address map.** The transmit registers sit at byte offset 4·n. The receive registers sit at 0x10 + 4·n. The status word is at 0x20 and the control word is at 0x24.
- **Bit layout.** Flags and enables are packed so that lane 0 takes the highest bit of each four-bit group. The empty group is bits 23..20 and the full group is bits 27..24.
- **Interrupts.** The control word holds an enable bit in the same position as each status flag. The interrupt output is the OR of every flag that is set and enabled.
- **Flags and enables are independent.** A flag always tracks lane traffic, whether or not its enable is set.

Top module: `ipc_msg_unit`

## Requirements
- R1: After reset, both status words read 0x00F00000, both control words read 0, both read-data outputs are 0 and both interrupts are low.
- R2: A write to transmit offset 4·n (n = 0..3) has three effects at the next clock edge. It loads the word into the partner's receive lane n. It sets the partner's full flag at status bit 27−n. It clears the writer's empty flag at status bit 23−n.
- R3: A read of receive offset 0x10 + 4·n returns the stored word. It clears the reader's full flag (bit 27−n) and sets the partner's empty flag (bit 23−n) at the same edge.
- R4: Status is at offset 0x20 and control at 0x24. For lane n, the empty flag and the transmit enable use bit 23−n, and the full flag and the receive enable use bit 27−n.
- R5: Control bits 27..20 are writable and all other control bits read 0. Writing 0 to the control word clears every enable.
- R6: Each side's interrupt equals the OR over lanes of (empty AND transmit enable) OR (full AND receive enable). It follows a control write with no extra delay.
- R7: Empty and full flags update in the same way whatever the enables hold. With all enables 0 the interrupt stays low while the flags still change.
- R8: Writes to the status offset and to receive offsets are ignored. Status bit 9 (partner reset pending) reads 0 because both sides share one reset.
- R9: Reads of transmit offsets, of offsets that are not word-aligned, and of offsets above 0x24 return 0.
- R10: A write to transmit lane n while the partner's lane n is still full replaces the stored word. The partner's full flag stays 1 and the writer's empty flag stays 0.
- R11: If one side writes lane n in the same cycle that the partner reads lane n, the read returns the old word and the write takes priority. Afterwards the lane is full and holds the new word.
- R12: Read data is registered. It appears on the read-data output in the cycle after the read strobe and does not change earlier.
- R13: The four lanes and the two directions hold their words and flags independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr | input | ADDR_W | Side A byte address |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A registered read data |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | ADDR_W | Side B byte address |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B registered read data |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench builds the unit with its default eight-bit address and the four lanes that the register map fixes. This configuration is small enough to sweep every lane in both directions and every one of the 256 control patterns on each side against a fixed mix of full and empty lanes. It also reaches the collision cases directly: overwriting a full lane, and a write meeting a partner read of the same lane in one cycle. Expected status words and interrupt levels are rebuilt in the bench from a lane model and plain bit arithmetic.

// File: rtl/ipc_mu_pkg.sv
package ipc_mu_pkg;
  localparam int LANES  = 4;
  localparam int WORD_W = 32;
  localparam int TE_LSB = 20;
  localparam int RF_LSB = 24;
  localparam logic [7:0] OFF_TX   = 8'h00;
  localparam logic [7:0] OFF_RX   = 8'h10;
  localparam logic [7:0] OFF_STAT = 8'h20;
  localparam logic [7:0] OFF_CTRL = 8'h24;

  // bit position of lane n inside a group whose lowest bit is lsb (lane 0 on top)
  function automatic int flag_pos(input int lsb, input int n);
    return lsb + LANES - 1 - n;
  endfunction

  function automatic logic [7:0] tx_off(input int n);
    return OFF_TX + 8'(4 * n);
  endfunction

  function automatic logic [7:0] rx_off(input int n);
    return OFF_RX + 8'(4 * n);
  endfunction

  function automatic logic [WORD_W-1:0] place_lanes(input logic [LANES-1:0] v, input int lsb);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int n = 0; n < LANES; n++) r[flag_pos(lsb, n)] = v[n];
    return r;
  endfunction

  function automatic logic [LANES-1:0] pick_lanes(input logic [WORD_W-1:0] w, input int lsb);
    logic [LANES-1:0] r;
    for (int n = 0; n < LANES; n++) r[n] = w[flag_pos(lsb, n)];
    return r;
  endfunction
endpackage

// File: rtl/ipc_mu_slot.sv
module ipc_mu_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  // receiver side word and full flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
      full <= 1'b0;
    end else if (push) begin
      dout <= din;
      full <= 1'b1;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  // sender side empty flag: raised only by the partner's read
  always_ff @(posedge clk) begin
    if (!rst_n)    empty <= 1'b1;
    else if (push) empty <= 1'b0;
    else if (pop)  empty <= 1'b1;
  end
endmodule

// File: rtl/ipc_mu_port.sv
module ipc_mu_port import ipc_mu_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         wr,
  input  logic                         rd,
  input  logic [WORD_W-1:0]            wdata,
  output logic [WORD_W-1:0]            rdata,
  output logic                         irq,
  input  logic [LANES-1:0]             te,
  input  logic [LANES-1:0]             rf,
  input  logic [LANES-1:0][WORD_W-1:0] rx_data,
  output logic [LANES-1:0]             tx_we,
  output logic [LANES-1:0]             rx_re,
  output logic [LANES-1:0]             tie,
  output logic [LANES-1:0]             rie
);
  logic              stat_hit;
  logic              ctrl_hit;
  logic [WORD_W-1:0] rd_mux;

  assign stat_hit = (addr == ADDR_W'(OFF_STAT));
  assign ctrl_hit = (addr == ADDR_W'(OFF_CTRL));

  always_comb begin
    tx_we = '0;
    rx_re = '0;
    for (int n = 0; n < LANES; n++) begin
      tx_we[n] = wr && (addr == ADDR_W'(tx_off(n)));
      rx_re[n] = rd && (addr == ADDR_W'(rx_off(n)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tie <= '0;
      rie <= '0;
    end else if (wr && ctrl_hit) begin
      tie <= pick_lanes(wdata, TE_LSB);
      rie <= pick_lanes(wdata, RF_LSB);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (stat_hit) rd_mux = place_lanes(te, TE_LSB) | place_lanes(rf, RF_LSB);
    if (ctrl_hit) rd_mux = place_lanes(tie, TE_LSB) | place_lanes(rie, RF_LSB);
    for (int n = 0; n < LANES; n++)
      if (addr == ADDR_W'(rx_off(n))) rd_mux = rx_data[n];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  assign irq = |((te & tie) | (rf & rie));
endmodule

// File: rtl/ipc_msg_unit.sv
module ipc_msg_unit import ipc_mu_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata,
  output logic              b_irq
);
  // named internal events, observed by the bound checker
  logic [LANES-1:0]             a_tx_we, a_rx_re, b_tx_we, b_rx_re;
  logic [LANES-1:0]             a_tie, a_rie, b_tie, b_rie;
  logic [LANES-1:0]             ab_full, ab_empty, ba_full, ba_empty;
  logic [LANES-1:0][WORD_W-1:0] ab_data, ba_data;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    ipc_mu_slot #(.W(WORD_W)) u_ab (
      .clk(clk), .rst_n(rst_n), .push(a_tx_we[n]), .pop(b_rx_re[n]),
      .din(a_wdata), .dout(ab_data[n]), .full(ab_full[n]), .empty(ab_empty[n])
    );
    ipc_mu_slot #(.W(WORD_W)) u_ba (
      .clk(clk), .rst_n(rst_n), .push(b_tx_we[n]), .pop(a_rx_re[n]),
      .din(b_wdata), .dout(ba_data[n]), .full(ba_full[n]), .empty(ba_empty[n])
    );
  end

  ipc_mu_port #(.ADDR_W(ADDR_W)) u_side_a (
    .clk(clk), .rst_n(rst_n), .addr(a_addr), .wr(a_wr), .rd(a_rd),
    .wdata(a_wdata), .rdata(a_rdata), .irq(a_irq),
    .te(ab_empty), .rf(ba_full), .rx_data(ba_data),
    .tx_we(a_tx_we), .rx_re(a_rx_re), .tie(a_tie), .rie(a_rie)
  );

  ipc_mu_port #(.ADDR_W(ADDR_W)) u_side_b (
    .clk(clk), .rst_n(rst_n), .addr(b_addr), .wr(b_wr), .rd(b_rd),
    .wdata(b_wdata), .rdata(b_rdata), .irq(b_irq),
    .te(ba_empty), .rf(ab_full), .rx_data(ab_data),
    .tx_we(b_tx_we), .rx_re(b_rx_re), .tie(b_tie), .rie(b_rie)
  );
endmodule

// File: rtl/ipc_mu_chk.sv
module ipc_mu_chk import ipc_mu_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] a_tx_we,
  input logic [LANES-1:0] a_rx_re,
  input logic [LANES-1:0] b_tx_we,
  input logic [LANES-1:0] b_rx_re,
  input logic [LANES-1:0] ab_full,
  input logic [LANES-1:0] ab_empty,
  input logic [LANES-1:0] ba_full,
  input logic [LANES-1:0] ba_empty,
  input logic [LANES-1:0] a_tie,
  input logic [LANES-1:0] a_rie,
  input logic [LANES-1:0] b_tie,
  input logic [LANES-1:0] b_rie,
  input logic             a_irq,
  input logic             b_irq
);
  // R10
  empty_full_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_empty == ~ab_full) && (ba_empty == ~ba_full));

  // R2
  tx_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_tx_we != '0) |=> (((ab_full & $past(a_tx_we)) == $past(a_tx_we)) &&
                         ((ab_empty & $past(a_tx_we)) == '0)));

  // R3
  rx_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((b_rx_re & ~a_tx_we) != '0) |=> ((ab_full & $past(b_rx_re & ~a_tx_we)) == '0));

  // R7
  quiet_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((b_tx_we == '0) && (a_rx_re == '0)) |=> $stable(ba_full));

  // R6
  irq_masked_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_tie == '0) && (a_rie == '0)) |-> !a_irq);

  // R6
  irq_masked_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((b_tie == '0) && (b_rie == '0)) |-> !b_irq);
endmodule

bind ipc_msg_unit ipc_mu_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_tx_we(a_tx_we), .a_rx_re(a_rx_re), .b_tx_we(b_tx_we), .b_rx_re(b_rx_re),
  .ab_full(ab_full), .ab_empty(ab_empty), .ba_full(ba_full), .ba_empty(ba_empty),
  .a_tie(a_tie), .a_rie(a_rie), .b_tie(b_tie), .b_rie(b_rie),
  .a_irq(a_irq), .b_irq(b_irq)
);

// File: tb/ipc_msg_unit_tb.sv
`timescale 1ns/1ps
module ipc_msg_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a_addr = '0, b_addr = '0;
  logic        a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model of lane contents
  logic [3:0]  full_ab = '0, full_ba = '0;
  logic [31:0] data_ab [4];
  logic [31:0] data_ba [4];

  always #2.5 clk = ~clk;

  ipc_msg_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_wr(a_wr), .a_rd(a_rd), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_addr(b_addr), .b_wr(b_wr), .b_rd(b_rd), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // lane n: empty at 23-n, full at 27-n
  function automatic logic [31:0] stat_word(input logic [3:0] te, input logic [3:0] rf);
    logic [31:0] s;
    s = 0;
    for (int n = 0; n < 4; n++)
      s = s + (32'(te[n]) << (23 - n)) + (32'(rf[n]) << (27 - n));
    return s;
  endfunction

  task automatic wr_op(input bit sb, input logic [7:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (!sb) begin a_addr = ad; a_wdata = d; a_wr = 1'b1; end
    else     begin b_addr = ad; b_wdata = d; b_wr = 1'b1; end
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
  endtask

  task automatic rd_op(input bit sb, input logic [7:0] ad, output logic [31:0] d);
    @(negedge clk);
    if (!sb) begin a_addr = ad; a_rd = 1'b1; end
    else     begin b_addr = ad; b_rd = 1'b1; end
    @(negedge clk);
    d = sb ? b_rdata : a_rdata;
    a_rd = 1'b0; b_rd = 1'b0;
  endtask

  task automatic chk_stat(input bit sb, input string req);
    logic [31:0] d;
    rd_op(sb, 8'h20, d);
    if (!sb) chk(req, d, stat_word(~full_ab, full_ba));
    else     chk(req, d, stat_word(~full_ba, full_ab));
  endtask

  task automatic send(input bit sb, input int n, input logic [31:0] w);
    wr_op(sb, 8'(4 * n), w);
    if (!sb) begin full_ab[n] = 1'b1; data_ab[n] = w; end
    else     begin full_ba[n] = 1'b1; data_ba[n] = w; end
  endtask

  task automatic recv(input bit sb, input int n, input string req);
    logic [31:0] d;
    rd_op(sb, 8'(8'h10 + 4 * n), d);
    if (sb) begin chk(req, d, data_ab[n]); full_ab[n] = 1'b0; end
    else    begin chk(req, d, data_ba[n]); full_ba[n] = 1'b0; end
  endtask

  function automatic logic exp_irq(input bit sb, input logic [7:0] e);
    logic [3:0] te, rf;
    logic r;
    te = sb ? ~full_ba : ~full_ab;
    rf = sb ? full_ab : full_ba;
    r = 1'b0;
    for (int n = 0; n < 4; n++)
      r = r | (te[n] & e[3 - n]) | (rf[n] & e[7 - n]);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, pv;
    for (int n = 0; n < 4; n++) begin data_ab[n] = '0; data_ba[n] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 a_irq", 32'(a_irq), 0);
    chk("R1 b_irq", 32'(b_irq), 0);
    chk("R1 a_rdata", a_rdata, 0);
    chk("R1 b_rdata", b_rdata, 0);
    rd_op(0, 8'h20, d); chk("R1 status A", d, 32'h00F0_0000);
    rd_op(1, 8'h20, d); chk("R1 status B", d, 32'h00F0_0000);
    rd_op(0, 8'h24, d); chk("R1 ctrl A", d, 0);
    rd_op(1, 8'h24, d); chk("R1 ctrl B", d, 0);

    // R2 R3 R4: every lane, both directions
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < 4; n++) begin
        send(s[0], n, (32'h1000_0000 * (s + 1)) + (32'h0101_0101 * (n + 1)) ^ 32'h00C3_5A00);
        chk_stat(!s[0], "R2 R4 partner full flag");
        chk_stat(s[0], "R2 R4 sender empty flag");
        recv(!s[0], n, "R3 received word");
        chk_stat(!s[0], "R3 reader full cleared");
        chk_stat(s[0], "R3 sender empty set");
      end
    end

    // R13 all lanes held at once, drained in reverse order
    for (int n = 0; n < 4; n++) send(0, n, 32'hBEEF_0000 + 32'(n * 17));
    for (int n = 0; n < 4; n++) send(1, n, 32'h7700_0000 + 32'(n * 3));
    chk_stat(1, "R13 B all full");
    for (int n = 3; n >= 0; n--) recv(1, n, "R13 lane independent A to B");
    for (int n = 3; n >= 0; n--) recv(0, n, "R13 lane independent B to A");
    chk_stat(0, "R13 A drained");

    // R6 R5: exhaustive enable sweep with lanes 0 and 2 of A to B full
    send(0, 0, 32'h1111_2222);
    send(0, 2, 32'h3333_4444);
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 256; e++) begin
        wr_op(s[0], 8'h24, 32'(e) << 20);
        chk("R6 irq sweep", 32'(s[0] ? b_irq : a_irq), 32'(exp_irq(s[0], 8'(e))));
        if (e % 37 == 0) begin
          rd_op(s[0], 8'h24, d);
          chk("R5 ctrl readback", d, 32'(e) << 20);
        end
      end
    end
    wr_op(0, 8'h24, 32'hFFFF_FFFF);
    rd_op(0, 8'h24, d); chk("R5 only bits 27..20 kept", d, 32'h0FF0_0000);
    chk("R6 irq all enabled", 32'(a_irq), 1);
    wr_op(0, 8'h24, 32'h0);
    rd_op(0, 8'h24, d); chk("R5 zero clears enables", d, 0);
    chk("R5 irq low after clear", 32'(a_irq), 0);

    // R7 flags move with enables off
    wr_op(1, 8'h24, 32'h0);
    send(0, 1, 32'h5555_6666);
    chk("R7 irq stays low", 32'(b_irq), 0);
    chk_stat(1, "R7 full flag set with enables off");
    chk_stat(0, "R7 empty flag cleared with enables off");
    for (int n = 0; n < 3; n++) recv(1, n, "R7 drain");

    // R8 ignored writes
    send(1, 2, 32'hA0A0_B1B1);
    wr_op(0, 8'h20, 32'hFFFF_FFFF);
    chk_stat(0, "R8 status write ignored, bit 9 low");
    wr_op(0, 8'h18, 32'hDEAD_DEAD);
    chk_stat(0, "R8 receive write ignored");
    chk_stat(1, "R8 partner unchanged");
    recv(0, 2, "R8 receive word kept");

    // R9 undecoded reads
    rd_op(0, 8'h28, d); chk("R9 offset 0x28", d, 0);
    rd_op(0, 8'h3C, d); chk("R9 offset 0x3C", d, 0);
    rd_op(0, 8'h21, d); chk("R9 unaligned", d, 0);
    rd_op(1, 8'h04, d); chk("R9 transmit offset", d, 0);

    // R10 overwrite of a full lane
    send(0, 1, 32'h0101_0101);
    send(0, 1, 32'h0202_0202);
    chk_stat(1, "R10 partner still full");
    chk_stat(0, "R10 sender still not empty");
    recv(1, 1, "R10 newest word");

    // R11 write meets partner read on the same lane
    send(0, 3, 32'hC0DE_0001);
    @(negedge clk);
    a_addr = 8'h0C; a_wdata = 32'hC0DE_0002; a_wr = 1'b1;
    b_addr = 8'h1C; b_rd = 1'b1;
    @(negedge clk);
    d = b_rdata;
    a_wr = 1'b0; b_rd = 1'b0;
    chk("R11 read returns old word", d, 32'hC0DE_0001);
    data_ab[3] = 32'hC0DE_0002;
    chk_stat(1, "R11 lane full after collision");
    chk_stat(0, "R11 sender empty low after collision");
    recv(1, 3, "R11 new word kept");

    // R12 registered read data
    send(0, 1, 32'h1234_5678);
    pv = b_rdata;
    @(negedge clk);
    b_addr = 8'h14; b_rd = 1'b1;
    #1;
    chk("R12 no change before edge", b_rdata, pv);
    @(negedge clk);
    chk("R12 data after one edge", b_rdata, 32'h1234_5678);
    b_rd = 1'b0;
    full_ab[1] = 1'b0;
    chk_stat(0, "R12 read side effect");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule